// File: doc/BRIEF.md
# Hardware Cursor Overlay Renderer

This block lays a 64x64 two-plane cursor over a stream of 32-bit pixels on their way to the display. A small register port sets the cursor's screen position, the base address of its image, a hotspot shift, two 24-bit colours, an enable flag and a lock flag. Each image row is stored as 16 bytes: eight bytes of an AND plane and then eight bytes of an XOR plane.

The timing logic outside the block gives it three things. A frame-start pulse copies the written settings into the working set. A per-line fetch pulse, sent during horizontal blanking, carries the number of the next line. The pixel stream itself comes with an x coordinate. On a fetch pulse the block decides whether the line crosses the cursor. If it does, the block reads that row's 16 mask bytes into a local line buffer through a byte-wide read port. During active video it then mixes each pixel from that buffer, with no memory traffic. Each pixel is passed through, replaced with a cursor colour, or inverted. Pixels at or beyond the active width are never touched.

Top module: `cursor_overlay`

## Requirements
- R1: Register map on `regAddr`: 0 holds the enable in bit 0. 1 holds the position, with X in bits [29:16] and Y in bits [11:0]. 2 holds the image base, masked with 0x07FFFFF0. 3 holds the hotspot, with horizontal shift in bits [21:16] and vertical shift in bits [5:0]. 4 holds colour 0 and 5 holds colour 1, each in bits [23:0].
- R2: A fetch pulse for line y reads exactly 16 bytes when all three hold: the cursor is enabled, cursorY <= y <= cursorY+63, and y <= `vDispEnd`. Otherwise it reads nothing and that line's pixels pass through unchanged.
- R3: The fetch reads addresses rowBase + 16*(y-cursorY) + k for k = 0..15, in ascending order, one per cycle. rowBase = base - hotX - 16*hotY, computed modulo 2^32. `memRdData` is expected one cycle after each read.
- R4: Screen pixel x maps to cursor column d = x - cursorX, for 0 <= d < 64. Its AND bit is bit 7-(d mod 8) of byte d/8, and its XOR bit is the same bit of byte 8+d/8.
- R5: When AND=1 and XOR=1 the output is the bitwise complement of the input pixel. When AND=1 and XOR=0 the input pixel passes through unchanged.
- R6: When AND=0 the output is 0xFF in bits [31:24], with colour 1 in bits [23:0] if XOR=1 and colour 0 if XOR=0.
- R7: A pixel with x >= `hActive` passes through unchanged, even if it lies inside the cursor's columns.
- R8: Bit 31 of a position, base or hotspot write sets the lock when it is 1 and clears it when it is 0. While the lock is set, frame start does not apply position, base or hotspot; it still applies the colours and the enable.
- R9: Written values take effect only at a frame-start pulse. A fetch before that pulse uses the previous settings.
- R10: `pixOutValid` and `pixOut` are registered and follow `pixValid` and `pixIn` by exactly one cycle. After reset, `pixOutValid` and `memRdEn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select |
| regWdata | input | 32 | Register write data |
| frameStart | input | 1 | Start-of-frame pulse; applies written settings |
| lineFetch | input | 1 | Pulse in blanking that requests the row for `fetchY` |
| fetchY | input | 12 | Line number of the next scanline |
| vDispEnd | input | 12 | Last displayed line |
| hActive | input | 14 | Active width in pixels |
| memRdEn | output | 1 | Byte read request |
| memRdAddr | output | 32 | Byte read address |
| memRdData | input | 8 | Read data, one cycle after the request |
| pixValid | input | 1 | Input pixel valid |
| pixX | input | 14 | Screen x of the input pixel |
| pixIn | input | 32 | Background pixel |
| pixOutValid | output | 1 | Output pixel valid |
| pixOut | output | 32 | Mixed pixel |

## Verification
Two cursor placements are swept across every pixel of the active line and a few pixels past it. The first placement is clipped by the active width partway through a row. The second sits on a wider line near its right edge. The mask memory returns a byte that is an arithmetic hash of its address, so all four mixing outcomes occur across the sweep and a swapped plane, a reversed bit order or a wrong byte index shows up as a pixel mismatch. Lines just outside the cursor's rows, just past the vertical end, with the cursor disabled and with the lock set are compared against lines that should hit, by counting the read requests and their addresses. This separates the hit test, the hotspot arithmetic and the frame-boundary and lock gating.

// File: rtl/cursor_ovl_pkg.sv
package cursor_ovl_pkg;
  parameter int CUR_DIM    = 64;
  parameter int MASK_BYTES = CUR_DIM / 8;
  parameter int ROW_BYTES  = 2 * MASK_BYTES;
  parameter int IDX_W      = $clog2(ROW_BYTES);

  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_POS   = 3'd1,
    SEL_BASE  = 3'd2,
    SEL_HOT   = 3'd3,
    SEL_CLR0  = 3'd4,
    SEL_CLR1  = 3'd5
  } regSel_t;

  typedef struct packed {
    logic             bufWe;
    logic [IDX_W-1:0] bufIdx;
    logic             rowClr;
    logic             rowSet;
  } fetchStrobe_t;
endpackage

// File: rtl/cursor_ovl_ctrl.sv
module cursor_ovl_ctrl
  import cursor_ovl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int X_W    = 14,
  parameter int Y_W    = 12,
  parameter int HOT_W  = 6,
  parameter int CLR_W  = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [2:0]         regAddr,
  input  logic [31:0]        regWdata,
  input  logic               frameStart,
  input  logic               lineFetch,
  input  logic [Y_W-1:0]     fetchY,
  input  logic [Y_W-1:0]     vDispEnd,
  output logic               memRdEn,
  output logic [ADDR_W-1:0]  memRdAddr,
  output fetchStrobe_t       strobe,
  output logic [X_W-1:0]     actX,
  output logic [CLR_W-1:0]   actClr0,
  output logic [CLR_W-1:0]   actClr1
);
  localparam int ROW_W    = $clog2(CUR_DIM);
  localparam int BYTE_SH  = $clog2(ROW_BYTES);
  localparam logic [31:0] BASE_MASK = 32'h07FF_FFF0;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ROW_BYTES - 1);

  // written (pending) settings
  logic              penEn;
  logic [X_W-1:0]    penX;
  logic [Y_W-1:0]    penY;
  logic [31:0]       penBase;
  logic [HOT_W-1:0]  penHotX, penHotY;
  logic [CLR_W-1:0]  penClr0, penClr1;
  logic              lockQ;

  // working settings
  logic              actEn;
  logic [Y_W-1:0]    actY;
  logic [ADDR_W-1:0] actRowBase;

  logic [ADDR_W-1:0] nextRowBase;
  assign nextRowBase = ADDR_W'(penBase) - ADDR_W'(penHotX)
                     - (ADDR_W'(penHotY) << BYTE_SH);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      penEn   <= 1'b0;
      penX    <= '0;
      penY    <= '0;
      penBase <= '0;
      penHotX <= '0;
      penHotY <= '0;
      penClr0 <= '0;
      penClr1 <= '0;
      lockQ   <= 1'b0;
    end else if (regWe) begin
      case (regSel_t'(regAddr))
        SEL_CTRL: penEn <= regWdata[0];
        SEL_POS: begin
          penX  <= regWdata[16 +: X_W];
          penY  <= regWdata[0 +: Y_W];
          lockQ <= regWdata[31];
        end
        SEL_BASE: begin
          penBase <= regWdata & BASE_MASK;
          lockQ   <= regWdata[31];
        end
        SEL_HOT: begin
          penHotX <= regWdata[16 +: HOT_W];
          penHotY <= regWdata[0 +: HOT_W];
          lockQ   <= regWdata[31];
        end
        SEL_CLR0: penClr0 <= regWdata[CLR_W-1:0];
        SEL_CLR1: penClr1 <= regWdata[CLR_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actEn      <= 1'b0;
      actX       <= '0;
      actY       <= '0;
      actRowBase <= '0;
      actClr0    <= '0;
      actClr1    <= '0;
    end else if (frameStart) begin
      actEn   <= penEn;
      actClr0 <= penClr0;
      actClr1 <= penClr1;
      if (!lockQ) begin
        actX       <= penX;
        actY       <= penY;
        actRowBase <= nextRowBase;
      end
    end
  end

  // row hit test
  logic [Y_W:0] dy;
  logic         rowHit;
  assign dy     = {1'b0, fetchY} - {1'b0, actY};
  assign rowHit = actEn && !dy[Y_W] && (dy[Y_W-1:0] < Y_W'(CUR_DIM))
                  && (fetchY <= vDispEnd);

  // fetch sequencer
  logic              busy;
  logic [IDX_W-1:0]  cnt;
  logic [ADDR_W-1:0] rowAddr;
  logic              rdVldQ;
  logic [IDX_W-1:0]  rdIdxQ;
  logic              accept;

  assign accept = lineFetch && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      cnt     <= '0;
      rowAddr <= '0;
      rdVldQ  <= 1'b0;
      rdIdxQ  <= '0;
    end else begin
      rdVldQ <= busy;
      rdIdxQ <= cnt;
      if (accept && rowHit) begin
        busy    <= 1'b1;
        cnt     <= '0;
        rowAddr <= actRowBase + (ADDR_W'(dy[ROW_W-1:0]) << BYTE_SH);
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt == LAST_IDX) busy <= 1'b0;
      end
    end
  end

  assign memRdEn   = busy;
  assign memRdAddr = rowAddr + ADDR_W'(cnt);

  always_comb begin
    strobe.bufWe  = rdVldQ;
    strobe.bufIdx = rdIdxQ;
    strobe.rowClr = accept;
    strobe.rowSet = rdVldQ && (rdIdxQ == LAST_IDX);
  end
endmodule

// File: rtl/cursor_ovl_datapath.sv
module cursor_ovl_datapath
  import cursor_ovl_pkg::*;
#(
  parameter int X_W   = 14,
  parameter int PIX_W = 32,
  parameter int CLR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  fetchStrobe_t      strobe,
  input  logic [7:0]        memRdData,
  input  logic              pixValid,
  input  logic [X_W-1:0]    pixX,
  input  logic [PIX_W-1:0]  pixIn,
  input  logic [X_W-1:0]    hActive,
  input  logic [X_W-1:0]    actX,
  input  logic [CLR_W-1:0]  actClr0,
  input  logic [CLR_W-1:0]  actClr1,
  output logic              pixOutValid,
  output logic [PIX_W-1:0]  pixOut
);
  localparam int COL_W  = $clog2(CUR_DIM);
  localparam int FILL_W = PIX_W - CLR_W;

  // line buffer, one register per mask byte
  logic [7:0] bufByte [ROW_BYTES];
  generate
    for (genvar g = 0; g < ROW_BYTES; g++) begin : g_byte
      logic [7:0] q;
      always_ff @(posedge clk) begin
        if (!rstN) q <= '0;
        else if (strobe.bufWe && strobe.bufIdx == IDX_W'(g)) q <= memRdData;
      end
      assign bufByte[g] = q;
    end
  endgenerate

  logic rowValid;
  always_ff @(posedge clk) begin
    if (!rstN)              rowValid <= 1'b0;
    else if (strobe.rowClr) rowValid <= 1'b0;
    else if (strobe.rowSet) rowValid <= 1'b1;
  end

  // column decode
  logic [X_W:0]       dx;
  logic               inCursor;
  logic [COL_W-4:0]   byteSel;
  logic [2:0]         bitSel;
  logic [7:0]         andByte, xorByte;
  logic               andBit, xorBit;
  logic [PIX_W-1:0]   mixed;

  assign dx       = {1'b0, pixX} - {1'b0, actX};
  assign inCursor = rowValid && !dx[X_W] && (dx[X_W-1:0] < X_W'(CUR_DIM))
                    && (pixX < hActive);
  assign byteSel  = dx[COL_W-1:3];
  assign bitSel   = 3'd7 - dx[2:0];
  assign andByte  = bufByte[IDX_W'(byteSel)];
  assign xorByte  = bufByte[IDX_W'(byteSel) + IDX_W'(MASK_BYTES)];
  assign andBit   = andByte[bitSel];
  assign xorBit   = xorByte[bitSel];

  always_comb begin
    if (!inCursor)
      mixed = pixIn;
    else if (andBit)
      mixed = xorBit ? ~pixIn : pixIn;
    else
      mixed = {{FILL_W{1'b1}}, (xorBit ? actClr1 : actClr0)};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixOutValid <= 1'b0;
      pixOut      <= '0;
    end else begin
      pixOutValid <= pixValid;
      pixOut      <= mixed;
    end
  end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_ovl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int X_W    = 14,
  parameter int Y_W    = 12,
  parameter int PIX_W  = 32,
  parameter int CLR_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  input  logic              frameStart,
  input  logic              lineFetch,
  input  logic [Y_W-1:0]    fetchY,
  input  logic [Y_W-1:0]    vDispEnd,
  input  logic [X_W-1:0]    hActive,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [7:0]        memRdData,
  input  logic              pixValid,
  input  logic [X_W-1:0]    pixX,
  input  logic [PIX_W-1:0]  pixIn,
  output logic              pixOutValid,
  output logic [PIX_W-1:0]  pixOut
);
  fetchStrobe_t     strobe;
  logic [X_W-1:0]   actX;
  logic [CLR_W-1:0] actClr0, actClr1;

  cursor_ovl_ctrl #(
    .ADDR_W(ADDR_W), .X_W(X_W), .Y_W(Y_W), .CLR_W(CLR_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .frameStart(frameStart), .lineFetch(lineFetch),
    .fetchY(fetchY), .vDispEnd(vDispEnd),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr),
    .strobe(strobe), .actX(actX), .actClr0(actClr0), .actClr1(actClr1)
  );

  cursor_ovl_datapath #(
    .X_W(X_W), .PIX_W(PIX_W), .CLR_W(CLR_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .memRdData(memRdData),
    .pixValid(pixValid), .pixX(pixX), .pixIn(pixIn), .hActive(hActive),
    .actX(actX), .actClr0(actClr0), .actClr1(actClr1),
    .pixOutValid(pixOutValid), .pixOut(pixOut)
  );
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk
  import cursor_ovl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int X_W    = 14,
  parameter int PIX_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memRdEn,
  input logic [ADDR_W-1:0] memRdAddr,
  input logic              pixValid,
  input logic [X_W-1:0]    pixX,
  input logic [PIX_W-1:0]  pixIn,
  input logic [X_W-1:0]    hActive,
  input logic              pixOutValid,
  input logic [PIX_W-1:0]  pixOut
);
  localparam int RUN_W = $clog2(ROW_BYTES) + 2;

  logic [RUN_W-1:0]  runLen;
  logic [ADDR_W-1:0] lastAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runLen   <= '0;
      lastAddr <= '0;
    end else begin
      runLen   <= memRdEn ? runLen + 1'b1 : '0;
      lastAddr <= memRdAddr;
    end
  end

  // R2: every read burst is exactly one row long
  p_burst_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!memRdEn && runLen != '0) |-> (runLen == RUN_W'(ROW_BYTES)));

  // R3: addresses step by one inside a burst
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && runLen != '0) |-> (memRdAddr == lastAddr + 1'b1));

  // R7: pixels at or past the active width are untouched
  p_clip_pass_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && pixX >= hActive) |=> (pixOut == $past(pixIn)));

  // R10: valid follows input valid by one cycle
  p_valid_lat_r10: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> pixOutValid);

  p_invalid_lat_r10: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> !pixOutValid);
endmodule

bind cursor_overlay cursor_overlay_chk i_chk (
  .clk(clk), .rstN(rstN), .memRdEn(memRdEn), .memRdAddr(memRdAddr),
  .pixValid(pixValid), .pixX(pixX), .pixIn(pixIn), .hActive(hActive),
  .pixOutValid(pixOutValid), .pixOut(pixOut)
);

// File: tb/test_cursor_overlay.sv
`timescale 1ns/1ps
module test_cursor_overlay;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic        frameStart = 1'b0;
  logic        lineFetch = 1'b0;
  logic [11:0] fetchY = '0;
  logic [11:0] vDispEnd = 12'd479;
  logic [13:0] hActive = 14'd64;
  logic        memRdEn;
  logic [31:0] memRdAddr;
  logic [7:0]  memRdData = '0;
  logic        pixValid = 1'b0;
  logic [13:0] pixX = '0;
  logic [31:0] pixIn = '0;
  logic        pixOutValid;
  logic [31:0] pixOut;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cursor_overlay i_cursor_overlay (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .frameStart(frameStart), .lineFetch(lineFetch),
    .fetchY(fetchY), .vDispEnd(vDispEnd), .hActive(hActive),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .pixValid(pixValid), .pixX(pixX), .pixIn(pixIn),
    .pixOutValid(pixOutValid), .pixOut(pixOut)
  );

  function automatic logic [7:0] memF(input logic [31:0] a);
    logic [7:0] t;
    t = a[7:0] * 8'd29;
    return t ^ a[15:8] ^ 8'h5A;
  endfunction

  // memory model with read log
  logic [31:0] rdLog [32];
  int rdN = 0;
  always @(posedge clk) begin
    if (memRdEn) begin
      memRdData <= memF(memRdAddr);
      if (rdN < 32) rdLog[rdN] = memRdAddr;
      rdN = rdN + 1;
    end
  end

  // reference model of settings
  logic        pEn = 0, mEn = 0, lockM = 0;
  int          pX = 0, pY = 0, mX = 0, mY = 0;
  logic [31:0] pOff = 0, mBase = 0;
  int          pHx = 0, pHy = 0;
  logic [23:0] pC0 = 0, pC1 = 0, mC0 = 0, mC1 = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWr(input int a, input logic [31:0] d);
    regWe = 1'b1; regAddr = 3'(a); regWdata = d;
    @(posedge clk); #1;
    regWe = 1'b0;
    case (a)
      0: pEn = d[0];
      1: begin pX = int'(d[29:16]); pY = int'(d[11:0]); lockM = d[31]; end
      2: begin pOff = d & 32'h07FF_FFF0; lockM = d[31]; end
      3: begin pHx = int'(d[21:16]); pHy = int'(d[5:0]); lockM = d[31]; end
      4: pC0 = d[23:0];
      5: pC1 = d[23:0];
      default: ;
    endcase
  endtask

  task automatic frame();
    frameStart = 1'b1;
    @(posedge clk); #1;
    frameStart = 1'b0;
    mEn = pEn; mC0 = pC0; mC1 = pC1;
    if (!lockM) begin
      mX = pX; mY = pY;
      mBase = pOff - 32'(pHx) - 32'(pHy * 16);
    end
  endtask

  function automatic bit rowHit(input int y);
    return mEn && y >= mY && (y - mY) < 64 && y <= int'(vDispEnd);
  endfunction

  task automatic expPix(input int x, input int y, input logic [31:0] bg,
                        output logic [31:0] e, output string tag);
    int d;
    logic [31:0] base;
    logic [7:0] aB, xB;
    logic a, xo;
    e = bg; tag = "R2";
    if (!rowHit(y)) return;
    tag = "R7";
    if (x >= int'(hActive)) return;
    tag = "R4";
    if (x < mX || x - mX >= 64) return;
    d = x - mX;
    base = mBase + 32'((y - mY) * 16);
    aB = memF(base + 32'(d / 8));
    xB = memF(base + 32'(8 + d / 8));
    a = aB[7 - d % 8];
    xo = xB[7 - d % 8];
    if (a) begin tag = "R5"; e = xo ? ~bg : bg; end
    else begin tag = "R6"; e = {8'hFF, xo ? mC1 : mC0}; end
  endtask

  task automatic doLine(input int y, input int xEnd, input string rdTag);
    bit hit;
    logic [31:0] e, bg;
    string tag;
    hit = rowHit(y);
    rdN = 0;
    fetchY = 12'(y); lineFetch = 1'b1;
    @(posedge clk); #1;
    lineFetch = 1'b0;
    repeat (20) @(posedge clk);
    #1;
    check(rdN == (hit ? 16 : 0), rdTag, 32'(rdN), hit ? 32'd16 : 32'd0);
    if (hit && rdN == 16)
      for (int k = 0; k < 16; k++)
        check(rdLog[k] == mBase + 32'((y - mY) * 16 + k), "R3", rdLog[k],
              mBase + 32'((y - mY) * 16 + k));
    for (int x = 0; x < xEnd; x++) begin
      bg = {8'(x), 8'(y), 8'h3C, 8'(x) ^ 8'h96};
      pixValid = 1'b1; pixX = 14'(x); pixIn = bg;
      @(posedge clk); #1;
      expPix(x, y, bg, e, tag);
      check(pixOut == e && pixOutValid, tag, pixOut, e);
    end
    pixValid = 1'b0;
    @(posedge clk); #1;
    check(!pixOutValid, "R10", 32'(pixOutValid), 32'd0);
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    check(!pixOutValid && !memRdEn, "R10", {31'd0, pixOutValid}, 32'd0);

    // placement A: clipped at the active width (R1, R7)
    regWr(0, 32'h1);
    regWr(1, (32'd20 << 16) | 32'd100);
    regWr(2, 32'h0000_1000);
    regWr(3, (32'd3 << 16) | 32'd2);
    regWr(4, 32'hAA12_3456);
    regWr(5, 32'h55AB_CDEF);
    frame();
    doLine(99, 72, "R2");
    doLine(100, 72, "R2");
    doLine(101, 72, "R2");
    doLine(130, 72, "R2");
    doLine(163, 72, "R2");
    doLine(164, 72, "R2");

    // placement B: wide line, cursor near right edge
    hActive = 14'd200;
    regWr(1, (32'd150 << 16) | 32'd0);
    regWr(2, 32'h0765_4320);
    regWr(3, 32'h0);
    frame();
    doLine(0, 210, "R2");
    doLine(63, 210, "R2");
    doLine(64, 8, "R2");

    // vertical display end
    vDispEnd = 12'd40;
    doLine(40, 4, "R2");
    doLine(41, 4, "R2");
    vDispEnd = 12'd600;

    // disabled cursor
    regWr(0, 32'h0);
    frame();
    doLine(10, 160, "R2");
    regWr(0, 32'h1);
    frame();

    // writes wait for frame start (R9)
    regWr(1, (32'd5 << 16) | 32'd500);
    doLine(10, 4, "R9");
    frame();
    doLine(10, 4, "R9");
    doLine(505, 80, "R9");

    // lock held through frame start (R8)
    regWr(1, 32'h8000_0000 | (32'd150 << 16) | 32'd0);
    regWr(4, 32'h0000_0F0F);
    frame();
    doLine(505, 80, "R8");
    doLine(10, 4, "R8");
    regWr(3, (32'd1 << 16) | 32'd1);
    frame();
    doLine(10, 210, "R8");
    regWr(2, 32'h8000_2000);
    frame();
    doLine(10, 4, "R8");
    regWr(1, (32'd5 << 16) | 32'd500);
    frame();
    doLine(505, 80, "R8");

    // base mask (R1)
    regWr(2, 32'h7FFF_FFFF);
    frame();
    doLine(505, 80, "R1");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule